// File: doc/BRIEF.md
# Interrupt Cause Priority and Exception-Register Unit

This unit sits at the retire point of a simple in-order integer/floating-point core. On each clock it takes the exception flags of the instruction being retired and builds a 32-bit cause vector from them. It masks that vector with the status register, decides whether control transfers to the interrupt service routine, and finds the interrupt level. It also sorts the interrupt into one of two kinds. A repeat interrupt re-executes the faulting instruction afterwards. A continue interrupt resumes after it.

The unit holds the status register, the saved-status, saved-cause, saved-PC pair and exception-data registers, and the delayed-PC pair (the PC of the instruction being retired and the PC that follows it). On an interrupt it fills the saved registers and sends both PCs to a fixed service-routine address, given as a parameter, and that address plus four. On a return-from-exception it restores the status register and the delayed PC from their saved copies. Without an interrupt, the delayed PC advances to the next PC and the next PC loads the candidate from the branch logic. Instruction decode and the datapath sit outside this block. The commit-block output tells the register files and the store path to drop the faulting instruction's writes.

Top module: `irq_cause_unit`

## Requirements
- R1: The cause vector uses a fixed layout, and none of these bits can be masked:
  - bit 0 is always 0;
  - bit 1 is illegal instruction;
  - bit 2 is fetch misalignment OR data misalignment;
  - bit 3 is fetch page fault;
  - bit 4 is data page fault;
  - bit 5 is trap.
- R2: Cause bit 6 is ALU overflow. It is forced to 0 whenever the fetch is misaligned or page-faults.
- R3: Cause bits 7..12 carry the six FP exception flags (flag k goes to bit 7+k), but only when the instruction is FP-class. Bits 13..31 are always 0.
- R4: The masked cause is the raw cause ANDed with the matching status bit for indices 6..11 and 13..31. Bits 0..5 and bit 12 pass through unmasked.
- R5: The jump output is high when any masked cause bit is set. The level output is the lowest set masked index, and it is 0 when there is no jump.
- R6: The repeat output is high when a jump is taken at a level below 5. The commit-block output equals jump AND repeat.
- R7: After a jump, the status register reads 0 and the saved cause holds the masked cause. The saved status holds the old status on a repeat interrupt, and the updated status (what the instruction would have written) otherwise.
- R8: After a jump, the saved PC and saved delayed PC hold the current next-PC and delayed PC on a repeat interrupt. Otherwise they hold the values computed without the interrupt.
- R9: On a jump, exception data is chosen by the first rule that applies, in this order:
  - the delayed PC on a fetch fault;
  - otherwise the trap immediate on a trap;
  - otherwise the effective address on a memory operation;
  - otherwise the upper FPU result word on an FP-class instruction;
  - otherwise 0.
- R10: After a jump, the delayed PC reads the service address and the next PC reads the service address + 4. Without a jump, the delayed PC takes the old next PC and the next PC takes the candidate.
- R11: On a return-from-exception without a jump, the status register loads the saved status and the delayed PC loads the saved delayed PC.
- R12: Synchronous reset clears every saved register and the status register, and loads the delayed PC and next PC with the service address and service address + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| illegalInstr | input | 1 | Illegal instruction |
| fetchMisal | input | 1 | Fetch address misaligned |
| fetchPageFault | input | 1 | Fetch page fault |
| dataMisal | input | 1 | Data address misaligned |
| dataPageFault | input | 1 | Data page fault |
| trapInstr | input | 1 | Trap instruction |
| aluOverflow | input | 1 | ALU overflow |
| fpClass | input | 1 | FP arithmetic, compare or int/FP move |
| fpExc | input | 6 | FP exception flags |
| memOp | input | 1 | Load or store instruction |
| rfeInstr | input | 1 | Return from exception |
| srWrEn | input | 1 | Instruction writes the status register |
| srWrData | input | 32 | Status value being written |
| pcpNext | input | 32 | Next-PC candidate from the branch logic |
| trapImm | input | 32 | Trap immediate |
| effAddr | input | 32 | Effective data address |
| fpuResultHi | input | 32 | Upper word of the FPU result |
| jisr | output | 1 | Jump to service routine |
| intLevel | output | 5 | Interrupt level |
| repeatInt | output | 1 | Repeat-type interrupt |
| commitBlock | output | 1 | Suppress the instruction's register and store writes |
| srOut | output | 32 | Status register |
| esrOut | output | 32 | Saved status |
| ecaOut | output | 32 | Saved masked cause |
| epcOut | output | 32 | Saved next PC |
| edpcOut | output | 32 | Saved delayed PC |
| edataOut | output | 32 | Exception data |
| dpcOut | output | 32 | Delayed PC |
| pcpOut | output | 32 | Next PC |

## Verification
The bench builds the unit with a 32-bit data width and the service address moved to 0x200. With that address, a redirect after a jump is distinguishable from a zeroed register, and the +4 successor is visible. Random flags and status masks reach every priority level, including the level 12 bit that cannot be masked and overflow hidden by a fetch fault. Return-from-exception and status writes make the status register, and so the mask, change continually between interrupts.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [2:0] {
    ED_FETCH,
    ED_TRAP,
    ED_MEM,
    ED_FPU,
    ED_NONE
  } edataSelT;

  typedef struct packed {
    logic     takeInt;
    logic     repeatInt;
    logic     rfe;
    logic     srWrite;
    edataSelT edataSel;
  } irqStrobeT;

  localparam int BIT_ILLEGAL = 1;
  localparam int BIT_MISAL   = 2;
  localparam int BIT_IPF     = 3;
  localparam int BIT_DPF     = 4;
  localparam int BIT_TRAP    = 5;
  localparam int BIT_OVF     = 6;
  localparam int BIT_FP_LO   = 7;
  localparam int FP_EXC_W    = 6;
  localparam int BIT_FP_HI   = BIT_FP_LO + FP_EXC_W - 1;

endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int REPEAT_LEVEL = 5,
  parameter int UNMASK_LO    = 6,
  localparam int LVL_W       = $clog2(DATA_W)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                illegalInstr,
  input  logic                fetchMisal,
  input  logic                fetchPageFault,
  input  logic                dataMisal,
  input  logic                dataPageFault,
  input  logic                trapInstr,
  input  logic                aluOverflow,
  input  logic                fpClass,
  input  logic [FP_EXC_W-1:0] fpExc,
  input  logic                memOp,
  input  logic                rfeInstr,
  input  logic                srWrEn,
  input  logic [DATA_W-1:0]   srCur,
  output logic [DATA_W-1:0]   maskedCause,
  output logic                jisr,
  output logic [LVL_W-1:0]    intLevel,
  output irqStrobeT           strobe
);

  logic [DATA_W-1:0] rawCause;
  logic              fetchFault;
  logic              isRepeat;

  assign fetchFault = fetchMisal | fetchPageFault;

  // Raw cause gathering: fixed layout, upper bits tied low
  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_cause
      if (gi == BIT_ILLEGAL) begin : g_ill
        assign rawCause[gi] = illegalInstr;
      end else if (gi == BIT_MISAL) begin : g_mis
        assign rawCause[gi] = fetchMisal | dataMisal;
      end else if (gi == BIT_IPF) begin : g_ipf
        assign rawCause[gi] = fetchPageFault;
      end else if (gi == BIT_DPF) begin : g_dpf
        assign rawCause[gi] = dataPageFault;
      end else if (gi == BIT_TRAP) begin : g_trp
        assign rawCause[gi] = trapInstr;
      end else if (gi == BIT_OVF) begin : g_ovf
        assign rawCause[gi] = aluOverflow & ~fetchFault;
      end else if (gi >= BIT_FP_LO && gi <= BIT_FP_HI) begin : g_fp
        assign rawCause[gi] = fpClass & fpExc[gi-BIT_FP_LO];
      end else begin : g_zero
        assign rawCause[gi] = 1'b0;
      end
    end

    // Status-register masking; low bits and the top FP bit are unmaskable
    for (gi = 0; gi < DATA_W; gi++) begin : g_mask
      if (gi >= UNMASK_LO && gi != BIT_FP_HI) begin : g_m
        assign maskedCause[gi] = rawCause[gi] & srCur[gi];
      end else begin : g_p
        assign maskedCause[gi] = rawCause[gi];
      end
    end
  endgenerate

  // Lowest set index wins
  always_comb begin
    intLevel = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (maskedCause[i]) intLevel = LVL_W'(i);
    end
  end

  assign jisr     = |maskedCause;
  assign isRepeat = jisr && (int'(intLevel) < REPEAT_LEVEL);

  always_comb begin
    strobe.takeInt   = jisr;
    strobe.repeatInt = isRepeat;
    strobe.rfe       = rfeInstr;
    strobe.srWrite   = srWrEn;
    if (fetchFault)     strobe.edataSel = ED_FETCH;
    else if (trapInstr) strobe.edataSel = ED_TRAP;
    else if (memOp)     strobe.edataSel = ED_MEM;
    else if (fpClass)   strobe.edataSel = ED_FPU;
    else                strobe.edataSel = ED_NONE;
  end

  // R2: a fetch fault hides overflow
  a_r2_ovf_hidden: assert property (@(posedge clk) disable iff (rst)
    fetchFault |-> !maskedCause[BIT_OVF]);

  // R5: the chosen level is a set bit with nothing set below it
  a_r5_level_lowest: assert property (@(posedge clk) disable iff (rst)
    jisr |-> (maskedCause[intLevel] &&
              ((maskedCause & ((DATA_W'(1) << intLevel) - DATA_W'(1))) == '0)));

  // R6: repeat implies a jump at a low level
  a_r6_repeat_low: assert property (@(posedge clk) disable iff (rst)
    strobe.repeatInt |-> (jisr && int'(intLevel) < REPEAT_LEVEL));

  // R4: bit 12 reaches the jump decision even with a zero status
  a_r4_unmaskable_fp: assert property (@(posedge clk) disable iff (rst)
    (fpClass && fpExc[FP_EXC_W-1]) |-> jisr);

endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] ISR_ADDR = 32'h0000_0000,
  localparam logic [DATA_W-1:0] ISR_START = DATA_W'(ISR_ADDR),
  localparam logic [DATA_W-1:0] ISR_NEXT  = DATA_W'(ISR_ADDR) + DATA_W'(4)
) (
  input  logic              clk,
  input  logic              rst,
  input  irqStrobeT         strobe,
  input  logic [DATA_W-1:0] maskedCause,
  input  logic [DATA_W-1:0] srWrData,
  input  logic [DATA_W-1:0] pcpNext,
  input  logic [DATA_W-1:0] trapImm,
  input  logic [DATA_W-1:0] effAddr,
  input  logic [DATA_W-1:0] fpuResultHi,
  output logic [DATA_W-1:0] srReg,
  output logic [DATA_W-1:0] esrReg,
  output logic [DATA_W-1:0] ecaReg,
  output logic [DATA_W-1:0] epcReg,
  output logic [DATA_W-1:0] edpcReg,
  output logic [DATA_W-1:0] edataReg,
  output logic [DATA_W-1:0] dpcReg,
  output logic [DATA_W-1:0] pcpReg
);

  logic [DATA_W-1:0] srUpd;
  logic [DATA_W-1:0] dpcUpd;
  logic [DATA_W-1:0] edataVal;

  assign srUpd  = strobe.rfe ? esrReg : (strobe.srWrite ? srWrData : srReg);
  assign dpcUpd = strobe.rfe ? edpcReg : pcpReg;

  always_comb begin
    unique case (strobe.edataSel)
      ED_FETCH: edataVal = dpcReg;
      ED_TRAP:  edataVal = trapImm;
      ED_MEM:   edataVal = effAddr;
      ED_FPU:   edataVal = fpuResultHi;
      default:  edataVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      srReg    <= '0;
      esrReg   <= '0;
      ecaReg   <= '0;
      epcReg   <= '0;
      edpcReg  <= '0;
      edataReg <= '0;
      dpcReg   <= ISR_START;
      pcpReg   <= ISR_NEXT;
    end else if (strobe.takeInt) begin
      srReg    <= '0;
      esrReg   <= strobe.repeatInt ? srReg  : srUpd;
      ecaReg   <= maskedCause;
      epcReg   <= strobe.repeatInt ? pcpReg : pcpNext;
      edpcReg  <= strobe.repeatInt ? dpcReg : dpcUpd;
      edataReg <= edataVal;
      dpcReg   <= ISR_START;
      pcpReg   <= ISR_NEXT;
    end else begin
      srReg    <= srUpd;
      dpcReg   <= dpcUpd;
      pcpReg   <= pcpNext;
    end
  end

  // R7: status cleared after a jump
  a_r7_sr_cleared: assert property (@(posedge clk) disable iff (rst)
    strobe.takeInt |=> (srReg == '0));

  // R10: redirect to the service routine
  a_r10_redirect: assert property (@(posedge clk) disable iff (rst)
    strobe.takeInt |=> (dpcReg == ISR_START && pcpReg == ISR_NEXT));

  // R8: a repeat interrupt saves the current PC pair
  a_r8_repeat_pcs: assert property (@(posedge clk) disable iff (rst)
    (strobe.takeInt && strobe.repeatInt) |=>
      (epcReg == $past(pcpReg) && edpcReg == $past(dpcReg)));

  // R11: return restores status and delayed PC
  a_r11_rfe_restore: assert property (@(posedge clk) disable iff (rst)
    (!strobe.takeInt && strobe.rfe) |=>
      (srReg == $past(esrReg) && dpcReg == $past(edpcReg)));

endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit
  import irq_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] ISR_ADDR = 32'h0000_0000,
  localparam int         LVL_W    = $clog2(DATA_W)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                illegalInstr,
  input  logic                fetchMisal,
  input  logic                fetchPageFault,
  input  logic                dataMisal,
  input  logic                dataPageFault,
  input  logic                trapInstr,
  input  logic                aluOverflow,
  input  logic                fpClass,
  input  logic [FP_EXC_W-1:0] fpExc,
  input  logic                memOp,
  input  logic                rfeInstr,
  input  logic                srWrEn,
  input  logic [DATA_W-1:0]   srWrData,
  input  logic [DATA_W-1:0]   pcpNext,
  input  logic [DATA_W-1:0]   trapImm,
  input  logic [DATA_W-1:0]   effAddr,
  input  logic [DATA_W-1:0]   fpuResultHi,
  output logic                jisr,
  output logic [LVL_W-1:0]    intLevel,
  output logic                repeatInt,
  output logic                commitBlock,
  output logic [DATA_W-1:0]   srOut,
  output logic [DATA_W-1:0]   esrOut,
  output logic [DATA_W-1:0]   ecaOut,
  output logic [DATA_W-1:0]   epcOut,
  output logic [DATA_W-1:0]   edpcOut,
  output logic [DATA_W-1:0]   edataOut,
  output logic [DATA_W-1:0]   dpcOut,
  output logic [DATA_W-1:0]   pcpOut
);

  irqStrobeT         strobe;
  logic [DATA_W-1:0] maskedCause;

  irq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .illegalInstr  (illegalInstr),
    .fetchMisal    (fetchMisal),
    .fetchPageFault(fetchPageFault),
    .dataMisal     (dataMisal),
    .dataPageFault (dataPageFault),
    .trapInstr     (trapInstr),
    .aluOverflow   (aluOverflow),
    .fpClass       (fpClass),
    .fpExc         (fpExc),
    .memOp         (memOp),
    .rfeInstr      (rfeInstr),
    .srWrEn        (srWrEn),
    .srCur         (srOut),
    .maskedCause   (maskedCause),
    .jisr          (jisr),
    .intLevel      (intLevel),
    .strobe        (strobe)
  );

  irq_datapath #(.DATA_W(DATA_W), .ISR_ADDR(ISR_ADDR)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .maskedCause(maskedCause),
    .srWrData   (srWrData),
    .pcpNext    (pcpNext),
    .trapImm    (trapImm),
    .effAddr    (effAddr),
    .fpuResultHi(fpuResultHi),
    .srReg      (srOut),
    .esrReg     (esrOut),
    .ecaReg     (ecaOut),
    .epcReg     (epcOut),
    .edpcReg    (edpcOut),
    .edataReg   (edataOut),
    .dpcReg     (dpcOut),
    .pcpReg     (pcpOut)
  );

  assign repeatInt   = strobe.repeatInt;
  assign commitBlock = jisr & repeatInt;

endmodule

// File: tb/irq_cause_unit_bench.sv
module irq_cause_unit_bench;

  localparam logic [31:0] ISR = 32'h0000_0200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        illegalInstr, fetchMisal, fetchPageFault, dataMisal, dataPageFault;
  logic        trapInstr, aluOverflow, fpClass, memOp, rfeInstr, srWrEn;
  logic [5:0]  fpExc;
  logic [31:0] srWrData, pcpNext, trapImm, effAddr, fpuResultHi;
  logic        jisr, repeatInt, commitBlock;
  logic [4:0]  intLevel;
  logic [31:0] srOut, esrOut, ecaOut, epcOut, edpcOut, edataOut, dpcOut, pcpOut;

  int checks = 0;
  int errors = 0;

  logic [31:0] mSr, mEsr, mEca, mEpc, mEdpc, mEdata, mDpc, mPcp;

  always #5 clk = ~clk;

  irq_cause_unit #(.DATA_W(32), .ISR_ADDR(ISR)) u_irq_cause_unit (
    .clk(clk), .rst(rst),
    .illegalInstr(illegalInstr), .fetchMisal(fetchMisal),
    .fetchPageFault(fetchPageFault), .dataMisal(dataMisal),
    .dataPageFault(dataPageFault), .trapInstr(trapInstr),
    .aluOverflow(aluOverflow), .fpClass(fpClass), .fpExc(fpExc),
    .memOp(memOp), .rfeInstr(rfeInstr), .srWrEn(srWrEn),
    .srWrData(srWrData), .pcpNext(pcpNext), .trapImm(trapImm),
    .effAddr(effAddr), .fpuResultHi(fpuResultHi),
    .jisr(jisr), .intLevel(intLevel), .repeatInt(repeatInt),
    .commitBlock(commitBlock), .srOut(srOut), .esrOut(esrOut),
    .ecaOut(ecaOut), .epcOut(epcOut), .edpcOut(edpcOut),
    .edataOut(edataOut), .dpcOut(dpcOut), .pcpOut(pcpOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearIn();
    illegalInstr = 0; fetchMisal = 0; fetchPageFault = 0; dataMisal = 0;
    dataPageFault = 0; trapInstr = 0; aluOverflow = 0; fpClass = 0;
    memOp = 0; rfeInstr = 0; srWrEn = 0; fpExc = '0;
    srWrData = '0; pcpNext = '0; trapImm = '0; effAddr = '0; fpuResultHi = '0;
  endtask

  task automatic checkState();
    chk("R7 sr", srOut, mSr);
    chk("R7 esr", esrOut, mEsr);
    chk("R7 eca", ecaOut, mEca);
    chk("R8 epc", epcOut, mEpc);
    chk("R8 edpc", edpcOut, mEdpc);
    chk("R9 edata", edataOut, mEdata);
    chk("R10 dpc", dpcOut, mDpc);
    chk("R10 pcp", pcpOut, mPcp);
  endtask

  // Inputs already applied after a falling edge: check the decision, advance the model
  task automatic step();
    logic [31:0] cause, mca, srU, dpcU, ed;
    int lvl;
    logic take, rep;
    #1;
    cause = '0;
    cause[1] = illegalInstr;                              // R1
    cause[2] = fetchMisal | dataMisal;
    cause[3] = fetchPageFault;
    cause[4] = dataPageFault;
    cause[5] = trapInstr;
    cause[6] = aluOverflow && !(fetchMisal || fetchPageFault); // R2
    for (int k = 0; k < 6; k++) cause[7+k] = fpClass && fpExc[k]; // R3
    for (int i = 0; i < 32; i++)                          // R4
      mca[i] = (i >= 6 && i != 12) ? (cause[i] & mSr[i]) : cause[i];
    lvl = 0; take = 0;
    for (int i = 0; i < 32; i++) if (mca[i] && !take) begin lvl = i; take = 1; end
    rep = take && (lvl < 5);
    chk("R5 jisr", {31'd0, jisr}, {31'd0, take});
    chk("R5 level", {27'd0, intLevel}, lvl[31:0]);
    chk("R6 repeat", {31'd0, repeatInt}, {31'd0, rep});
    chk("R6 commitBlock", {31'd0, commitBlock}, {31'd0, rep});
    srU  = rfeInstr ? mEsr : (srWrEn ? srWrData : mSr);
    dpcU = rfeInstr ? mEdpc : mPcp;
    if (fetchMisal || fetchPageFault) ed = mDpc;
    else if (trapInstr)               ed = trapImm;
    else if (memOp)                   ed = effAddr;
    else if (fpClass)                 ed = fpuResultHi;
    else                              ed = '0;
    if (take) begin
      mEsr = rep ? mSr : srU;
      mEca = mca;
      mEpc = rep ? mPcp : pcpNext;
      mEdpc = rep ? mDpc : dpcU;
      mEdata = ed;
      mSr = '0;
      mDpc = ISR; mPcp = ISR + 32'd4;
    end else begin
      mSr = srU; mDpc = dpcU; mPcp = pcpNext;         // R11 on rfe
    end
    @(posedge clk);
    @(negedge clk);
    checkState();
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clearIn();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    mSr = '0; mEsr = '0; mEca = '0; mEpc = '0; mEdpc = '0; mEdata = '0;
    mDpc = ISR; mPcp = ISR + 32'd4;
    checkState();                          // R12 reset state
    chk("R12 no jump at reset", {31'd0, jisr}, 32'd0);

    // Open every mask bit, then step normally
    srWrEn = 1; srWrData = 32'hFFFF_FFFF; pcpNext = 32'h1000; step();
    clearIn(); pcpNext = 32'h1004; step();
    // R2: overflow hidden behind fetch page fault (level 3, EDATA = DPC)
    clearIn(); aluOverflow = 1; fetchPageFault = 1; trapInstr = 1; pcpNext = 32'h1008; step();
    // R11: return restores status and delayed PC
    clearIn(); rfeInstr = 1; pcpNext = 32'h2000; step();
    // R9: trap immediate preferred over memory address, continue-type
    clearIn(); trapInstr = 1; memOp = 1; trapImm = 32'hABCD; effAddr = 32'h55; pcpNext = 32'h2004; step();
    // R4: status now 0, bit 12 still reaches the jump, bit 7 does not
    clearIn(); fpClass = 1; fpExc = 6'b100001; fpuResultHi = 32'hF00D; pcpNext = 32'h3000; step();
    // R3: FP flags ignored when not FP-class
    clearIn(); fpExc = 6'b111111; pcpNext = 32'h3004; step();

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      clearIn();
      illegalInstr   = ($urandom % 24) == 0;
      fetchMisal     = ($urandom % 40) == 0;
      fetchPageFault = ($urandom % 40) == 0;
      dataMisal      = ($urandom % 30) == 0;
      dataPageFault  = ($urandom % 30) == 0;
      trapInstr      = ($urandom % 20) == 0;
      aluOverflow    = ($urandom % 6) == 0;
      fpClass        = ($urandom % 4) == 0;
      fpExc          = 6'($urandom) & 6'($urandom);
      memOp          = ($urandom % 3) == 0;
      rfeInstr       = ($urandom % 10) == 0;
      srWrEn         = ($urandom % 3) == 0;
      srWrData       = $urandom;
      pcpNext        = $urandom & 32'hFFFF_FFFC;
      trapImm        = $urandom;
      effAddr        = $urandom;
      fpuResultHi    = $urandom;
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule